// File: doc/BRIEF.md
# Voice Waveform Selector with Noise Generator

This block forms the 12-bit digital waveform word of one synthesizer voice. It takes the upper bits of the voice's phase accumulator, the pulse comparator result, the top bit of a neighbouring voice's accumulator and four waveform enables. From these it produces a triangle, a sawtooth, a pulse level and a pseudo-random noise word. The noise word comes from a 23-bit shift register that advances on rising edges of one accumulator bit.

When several of triangle, sawtooth and pulse are enabled together, their words are combined bitwise. Noise mixed with anything else yields silence. Ring modulation changes the bit that folds the triangle. A build-time option decides whether the sawtooth's top bit is taken directly from the accumulator or from a register one clock behind it. The output drives the voice's digital-to-analog converter.

Top module: `voice_wave_mixer`

## Requirements
- R1: With no waveform enable set, the output word is 0.
- R2: Sawtooth alone outputs {S, acc[22:12]}, where S is acc[23] in the direct variant (REG_SAW_MSB=0). The port acc_top_i carries acc[23:11], so acc[23] is acc_top_i[12].
- R3: Triangle alone with ring modulation off outputs acc[22:11], with every bit XORed with acc[23].
- R4: With ring modulation on, the triangle fold bit becomes acc[23] XOR (NOT ring_msb_i).
- R5: Pulse alone copies pulse_i into all 12 output bits, so a set pulse bit gives 0xFFF.
- R6: Any mix of two or three of triangle, sawtooth and pulse outputs the bitwise AND of the individual words.
- R7: Noise alone outputs the shift register's bits 20, 18, 14, 11, 9, 5, 2 and 0 on output bits 11 down to 4, in that order, with output bits 3:0 at 0.
- R8: Noise enabled together with any other waveform gives an output of 0.
- R9: The noise register is all ones during and after reset. It shifts left by one at a clock edge where acc[19] (acc_top_i[8]) is 1 and was 0 at the previous edge, taking bit22 XOR bit17 into bit 0. The first edge after reset never shifts it.
- R10: In the registered variant (REG_SAW_MSB=1), the sawtooth top bit is acc[23] as sampled at the previous clock edge, and it is 0 in reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_top_i | input | 13 | Accumulator bits 23 down to 11 |
| ring_msb_i | input | 1 | Top accumulator bit of the neighbouring voice |
| ring_en_i | input | 1 | Ring-modulation enable |
| pulse_i | input | 1 | Pulse comparator result |
| sel_tri_i | input | 1 | Triangle enable |
| sel_saw_i | input | 1 | Sawtooth enable |
| sel_pulse_i | input | 1 | Pulse enable |
| sel_noise_i | input | 1 | Noise enable |
| wave_o | output | 12 | Combined waveform word |

## Verification
The assertions take the inputs to be stable around each clock edge and treat the accumulator as arbitrary. They assume nothing about it advancing monotonically, so the noise-hold property depends only on the sampled history of acc[19]. The stimulus changes the accumulator only at falling edges and sweeps the enables, ring bits and pulse bit inside the low half-cycle. Every sampled value is therefore settled and is seen by one rising edge only. The accumulator sequence forces acc[19] to toggle often, so the noise register steps many times during the run.

// File: rtl/wvsel_pkg.sv
package wvsel_pkg;

   localparam int NOISE_TAPS = 8;

   typedef struct packed {
      logic noise;
      logic pulse;
      logic saw;
      logic tri_w;
   } wsel_t;

   // shift-register bit feeding noise output bit (OUT_W-NOISE_TAPS+k)
   function automatic int noise_tap(input int k);
      case (k)
         0:       return 0;
         1:       return 2;
         2:       return 5;
         3:       return 9;
         4:       return 11;
         5:       return 14;
         6:       return 18;
         default: return 20;
      endcase
   endfunction

endpackage

// File: rtl/wvsel_lfsr.sv
module wvsel_lfsr #(
   parameter int LFSR_W = 23,
   parameter int FB_A   = 22,
   parameter int FB_B   = 17
) (
   input  logic clk,
   input  logic rst_n,
   input  logic step_bit_i,
   output logic [wvsel_pkg::NOISE_TAPS-1:0] noise_o
);
   import wvsel_pkg::*;

   logic [LFSR_W-1:0] state_q;
   logic              prev_q;
   logic              advance;

   generate
      if (noise_tap(NOISE_TAPS-1) >= LFSR_W) begin : g_bad_taps
         $error("noise tap beyond shift register width");
      end
      if (FB_A >= LFSR_W || FB_B >= LFSR_W) begin : g_bad_fb
         $error("feedback tap beyond shift register width");
      end
   endgenerate

   assign advance = step_bit_i & ~prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= '1;
         prev_q  <= 1'b1;
      end else begin
         prev_q <= step_bit_i;
         if (advance)
            state_q <= {state_q[LFSR_W-2:0], state_q[FB_A] ^ state_q[FB_B]};
      end
   end

   // every state bit reaches either the feedback or a noise tap
   logic unused_mid;
   assign unused_mid = ^state_q;

   generate
      for (genvar k = 0; k < NOISE_TAPS; k++) begin : g_tap
         assign noise_o[k] = state_q[noise_tap(k)];
      end
   endgenerate

endmodule

// File: rtl/wvsel_ramp.sv
module wvsel_ramp #(
   parameter int OUT_W = 12
) (
   input  logic [OUT_W:0]   acc_top_i,
   input  logic             saw_msb_i,
   input  logic             ring_en_i,
   input  logic             ring_msb_i,
   output logic [OUT_W-1:0] tri_o,
   output logic [OUT_W-1:0] saw_o
);
   logic fold;

   always_comb begin
      if (ring_en_i)
         fold = acc_top_i[OUT_W] ^ ~ring_msb_i;
      else
         fold = acc_top_i[OUT_W];
   end

   assign tri_o = acc_top_i[OUT_W-1:0] ^ {OUT_W{fold}};
   assign saw_o = {saw_msb_i, acc_top_i[OUT_W-1:1]};

endmodule

// File: rtl/wvsel_mix.sv
module wvsel_mix #(
   parameter int OUT_W = 12
) (
   input  wvsel_pkg::wsel_t sel_i,
   input  logic [OUT_W-1:0] tri_i,
   input  logic [OUT_W-1:0] saw_i,
   input  logic             pulse_i,
   input  logic [OUT_W-1:0] noise_i,
   output logic [OUT_W-1:0] wave_o
);
   logic             any_ramp;
   logic [OUT_W-1:0] and_word;

   assign any_ramp = sel_i.tri_w | sel_i.saw | sel_i.pulse;

   always_comb begin
      and_word = '1;
      if (sel_i.tri_w) and_word = and_word & tri_i;
      if (sel_i.saw)   and_word = and_word & saw_i;
      if (sel_i.pulse) and_word = and_word & {OUT_W{pulse_i}};
   end

   always_comb begin
      if (sel_i.noise)
         wave_o = any_ramp ? '0 : noise_i;
      else if (!any_ramp)
         wave_o = '0;
      else
         wave_o = and_word;
   end

endmodule

// File: rtl/voice_wave_mixer.sv
module voice_wave_mixer #(
   parameter int ACC_W       = 24,
   parameter int OUT_W       = 12,
   parameter int LFSR_W      = 23,
   parameter int FB_A        = 22,
   parameter int FB_B        = 17,
   parameter int STEP_BIT    = 19,
   parameter int REG_SAW_MSB = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [OUT_W:0]   acc_top_i,
   input  logic             ring_msb_i,
   input  logic             ring_en_i,
   input  logic             pulse_i,
   input  logic             sel_tri_i,
   input  logic             sel_saw_i,
   input  logic             sel_pulse_i,
   input  logic             sel_noise_i,
   output logic [OUT_W-1:0] wave_o
);
   import wvsel_pkg::*;

   localparam int ACC_LSB  = ACC_W - 1 - OUT_W;
   localparam int STEP_IDX = STEP_BIT - ACC_LSB;
   localparam int PAD_W    = OUT_W - NOISE_TAPS;

   generate
      if (OUT_W <= NOISE_TAPS) begin : g_bad_out
         $error("output width must exceed the noise tap count");
      end
      if (ACC_LSB < 0) begin : g_bad_acc
         $error("accumulator narrower than output plus one");
      end
      if (STEP_IDX < 0 || STEP_IDX > OUT_W) begin : g_bad_step
         $error("noise step bit outside the supplied accumulator bits");
      end
      if (REG_SAW_MSB != 0 && REG_SAW_MSB != 1) begin : g_bad_var
         $error("REG_SAW_MSB must be 0 or 1");
      end
   endgenerate

   wsel_t                  sel;
   logic                   saw_msb;
   logic [OUT_W-1:0]       tri_w;
   logic [OUT_W-1:0]       saw_w;
   logic [NOISE_TAPS-1:0]  noise_bits;
   logic [OUT_W-1:0]       noise_w;

   assign sel = '{noise: sel_noise_i, pulse: sel_pulse_i,
                  saw: sel_saw_i, tri_w: sel_tri_i};

   generate
      if (REG_SAW_MSB != 0) begin : g_saw_reg
         logic msb_q;
         always_ff @(posedge clk) begin
            if (!rst_n) msb_q <= 1'b0;
            else        msb_q <= acc_top_i[OUT_W];
         end
         assign saw_msb = msb_q;
      end else begin : g_saw_direct
         assign saw_msb = acc_top_i[OUT_W];
      end
   endgenerate

   wvsel_lfsr #(
      .LFSR_W (LFSR_W),
      .FB_A   (FB_A),
      .FB_B   (FB_B)
   ) u_lfsr (
      .clk        (clk),
      .rst_n      (rst_n),
      .step_bit_i (acc_top_i[STEP_IDX]),
      .noise_o    (noise_bits)
   );

   assign noise_w = {noise_bits, {PAD_W{1'b0}}};

   wvsel_ramp #(
      .OUT_W (OUT_W)
   ) u_ramp (
      .acc_top_i  (acc_top_i),
      .saw_msb_i  (saw_msb),
      .ring_en_i  (ring_en_i),
      .ring_msb_i (ring_msb_i),
      .tri_o      (tri_w),
      .saw_o      (saw_w)
   );

   wvsel_mix #(
      .OUT_W (OUT_W)
   ) u_mix (
      .sel_i   (sel),
      .tri_i   (tri_w),
      .saw_i   (saw_w),
      .pulse_i (pulse_i),
      .noise_i (noise_w),
      .wave_o  (wave_o)
   );

endmodule

// File: rtl/wvsel_check.sv
module wvsel_check #(
   parameter int OUT_W       = 12,
   parameter int STEP_IDX    = 8,
   parameter int REG_SAW_MSB = 0
) (
   input logic             clk,
   input logic             rst_n,
   input logic [OUT_W:0]   acc_top_i,
   input logic             pulse_i,
   input logic             sel_tri_i,
   input logic             sel_saw_i,
   input logic             sel_pulse_i,
   input logic             sel_noise_i,
   input logic [OUT_W-1:0] noise_w,
   input logic [OUT_W-1:0] wave_o
);
   logic only_saw;
   assign only_saw = sel_saw_i & ~sel_tri_i & ~sel_pulse_i & ~sel_noise_i;

   assert_silent_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!sel_tri_i && !sel_saw_i && !sel_pulse_i && !sel_noise_i) |-> (wave_o == '0));

   assert_saw_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
      only_saw |-> (wave_o[OUT_W-2:0] == acc_top_i[OUT_W-1:1]));

   assert_pulse_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_pulse_i && !sel_tri_i && !sel_saw_i && !sel_noise_i)
      |-> (wave_o == {OUT_W{pulse_i}}));

   assert_noise_mix_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_noise_i && (sel_tri_i || sel_saw_i || sel_pulse_i)) |-> (wave_o == '0));

   assert_noise_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(acc_top_i[STEP_IDX] && !$past(acc_top_i[STEP_IDX])) |=> $stable(noise_w));

   generate
      if (REG_SAW_MSB != 0) begin : g_reg_chk
         assert_saw_delay_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (only_saw && $past(rst_n)) |-> (wave_o[OUT_W-1] == $past(acc_top_i[OUT_W])));
      end else begin : g_dir_chk
         assert_saw_direct_R2: assert property (@(posedge clk) disable iff (!rst_n)
            only_saw |-> (wave_o[OUT_W-1] == acc_top_i[OUT_W]));
      end
   endgenerate

endmodule

bind voice_wave_mixer wvsel_check #(
   .OUT_W       (OUT_W),
   .STEP_IDX    (STEP_IDX),
   .REG_SAW_MSB (REG_SAW_MSB)
) u_wvsel_check (
   .clk         (clk),
   .rst_n       (rst_n),
   .acc_top_i   (acc_top_i),
   .pulse_i     (pulse_i),
   .sel_tri_i   (sel_tri_i),
   .sel_saw_i   (sel_saw_i),
   .sel_pulse_i (sel_pulse_i),
   .sel_noise_i (sel_noise_i),
   .noise_w     (noise_w),
   .wave_o      (wave_o)
);

// File: tb/voice_wave_mixer_test.sv
`timescale 1ns/1ps
module voice_wave_mixer_test;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [12:0] acc;
   logic        ring_msb, ring_en, pulse;
   logic [3:0]  sel;          // {noise, pulse, saw, tri}
   logic [11:0] w_dir, w_reg;

   always #4 clk = ~clk;      // 125 MHz

   voice_wave_mixer #(.REG_SAW_MSB(0)) uut (
      .clk(clk), .rst_n(rst_n), .acc_top_i(acc), .ring_msb_i(ring_msb),
      .ring_en_i(ring_en), .pulse_i(pulse), .sel_tri_i(sel[0]),
      .sel_saw_i(sel[1]), .sel_pulse_i(sel[2]), .sel_noise_i(sel[3]),
      .wave_o(w_dir));

   voice_wave_mixer #(.REG_SAW_MSB(1)) uut_reg (
      .clk(clk), .rst_n(rst_n), .acc_top_i(acc), .ring_msb_i(ring_msb),
      .ring_en_i(ring_en), .pulse_i(pulse), .sel_tri_i(sel[0]),
      .sel_saw_i(sel[1]), .sel_pulse_i(sel[2]), .sel_noise_i(sel[3]),
      .wave_o(w_reg));

   int  n_run  = 0;
   int  n_fail = 0;
   bit  done   = 0;

   logic [22:0] m_lfsr;
   logic        m_prev19;
   logic        m_msbq;

   task automatic check(input string tag, input logic [11:0] got, input logic [11:0] exp);
      n_run++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s acc=%h sel=%b ring=%b/%b pulse=%b actual=%h expected=%h",
                  tag, acc, sel, ring_en, ring_msb, pulse, got, exp);
      end
   endtask

   function automatic logic [11:0] expect_word(input bit regv);
      logic fold;
      logic [11:0] t, s, p, n, r;
      fold = ring_en ? (acc[12] ^ ~ring_msb) : acc[12];     // R3 R4
      t = acc[11:0] ^ {12{fold}};
      s = {(regv ? m_msbq : acc[12]), acc[11:1]};           // R2 R10
      p = {12{pulse}};                                      // R5
      n = {m_lfsr[20], m_lfsr[18], m_lfsr[14], m_lfsr[11],
           m_lfsr[9], m_lfsr[5], m_lfsr[2], m_lfsr[0], 4'b0000}; // R7
      if (sel[3]) return (sel[2:0] != 3'b000) ? 12'h000 : n; // R8
      if (sel[2:0] == 3'b000) return 12'h000;                // R1
      r = 12'hFFF;                                           // R6
      if (sel[0]) r &= t;
      if (sel[1]) r &= s;
      if (sel[2]) r &= p;
      return r;
   endfunction

   function automatic string tag_of(input bit regv);
      if (sel == 4'b0000) return "R1";
      if (sel[3] && sel[2:0] != 3'b000) return "R8";
      if (sel == 4'b1000) return "R7_R9";
      if (sel == 4'b0010) return regv ? "R10" : "R2";
      if (sel == 4'b0001) return ring_en ? "R4" : "R3";
      if (sel == 4'b0100) return "R5";
      return "R6";
   endfunction

   task automatic sweep();
      for (int s = 0; s < 16; s++) begin
         for (int c = 0; c < 8; c++) begin
            sel      = s[3:0];
            ring_en  = c[0];
            ring_msb = c[1];
            pulse    = c[2];
            #0.025;
            check({tag_of(0), " direct"}, w_dir, expect_word(0));
            check({tag_of(1), " registered"}, w_reg, expect_word(1));
         end
      end
   endtask

   task automatic model_edge();
      logic fb;
      if (!rst_n) begin
         m_lfsr   = '1;
         m_prev19 = 1'b1;
         m_msbq   = 1'b0;
      end else begin
         if (acc[8] && !m_prev19) begin                    // R9 step on rise of acc[19]
            fb     = m_lfsr[22] ^ m_lfsr[17];
            m_lfsr = {m_lfsr[21:0], fb};
         end
         m_prev19 = acc[8];
         m_msbq   = acc[12];
      end
   endtask

   initial begin
      rst_n = 1'b0; acc = 13'h1100; ring_msb = 0; ring_en = 0; pulse = 0; sel = 4'b1000;
      m_lfsr = '1; m_prev19 = 1'b1; m_msbq = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R9: all-ones register in reset gives 0xFF0 on noise alone
      check("R9 reset noise", w_dir, 12'hFF0);
      check("R9 reset noise", w_reg, 12'hFF0);
      // R10: registered sawtooth top bit is 0 in reset; R2 direct follows acc[23]
      sel = 4'b0010; acc = 13'h1000;
      #0.5;
      check("R10 reset saw", w_reg, 12'h000);
      check("R2 reset saw", w_dir, 12'h800);
      // R1 in reset
      sel = 4'b0000;
      #0.5;
      check("R1 reset idle", w_dir, 12'h000);
      // acc[19] high at release: first edge after reset must not step (R9)
      acc = 13'h0100;
      rst_n = 1'b1;
      for (int i = 0; i < 400; i++) begin
         @(posedge clk);
         model_edge();
         @(negedge clk);
         acc = 13'((i * 13'h0A5B) ^ (i[0] ? 13'h0100 : 13'h0000) ^ (i[4] ? 13'h1000 : 13'h0000));
         sweep();
      end
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule